// File: doc/BRIEF.md
# Serial Rice Block Decoder

This block turns a serial compressed bitstream back into fixed-width samples. Bits arrive one per clock, each qualified by a valid strobe. A block opens with a short header that selects how many low bits of every sample were sent uncoded. The block then holds a fixed number of samples. For each sample the decoder first captures the uncoded low bits. It then counts the zero bits that follow, up to the closing one. The count becomes the upper part of the sample, and the uncoded bits fill the lower part.

Each rebuilt sample is presented with a one-cycle valid pulse. A second pulse marks the last sample of a block. A zero run too long for the selected split makes the decoder stop. It raises a sticky error and ignores the line until a resync pulse returns it to header parsing.

The controller has four states:
- `ST_HEADER` collects header bits.
- `ST_LOW` collects uncoded low bits.
- `ST_ZEROS` counts the zero run.
- `ST_HALT` waits after an error.

Its transitions are:
- HEADER→LOW when the last header bit arrives and k>0.
- HEADER→ZEROS when the last header bit arrives and k=0.
- LOW→ZEROS after the k-th low bit.
- ZEROS→LOW on a closing one when samples remain and k>0.
- ZEROS→ZEROS on a closing one when samples remain and k=0.
- ZEROS→HEADER on the closing one of the last sample.
- ZEROS→HALT on overflow.
- any state→HEADER on resync.

Top module: `rbd_block_decoder`

## Requirements
- R1: After reset, `samp_vld`, `blk_done`, `err_flag` and `samp_data` are all 0, and the decoder waits for a header.
- R2: A block starts with a 3-bit header sent MSB first. Header value v (0 to 7) selects the split k = v.
- R3: After the header, and again at the start of every sample, the next k bits (MSB first) are the low k bits of the sample.
- R4: Each following '0' adds one to a count that restarts at zero for every sample. A '1' closes the sample. The output is (count << k) | low bits, with `samp_vld` high for one cycle, in the cycle after the closing bit is accepted.
- R5: Exactly 8 samples make a block. `blk_done` is high together with the eighth `samp_vld`, and the next accepted bit is the first header bit of the next block.
- R6: Cycles with `bit_vld` low change nothing, whatever `bit_in` carries.
- R7: A '0' accepted while the count already equals 2^(8-k)-1 sets `err_flag`. The flag stays set, and no sample is produced, until resync.
- R8: A `resync` pulse, in any state, clears `err_flag` in the next cycle and returns the decoder to header parsing with a fresh sample index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial stream bit |
| resync | input | 1 | Return to header parsing, clear error |
| samp_vld | output | 1 | One-cycle strobe for a rebuilt sample |
| samp_data | output | 8 | Rebuilt sample |
| blk_done | output | 1 | Marks the eighth sample of a block |
| err_flag | output | 1 | Sticky zero-run overflow flag |

## Verification
The properties rely on two input assumptions.
- Bits count only when `bit_vld` is high.
- `resync` is a single-cycle pulse that is not combined with an accepted bit that matters.

The stimulus meets both. It drives bits at the falling edge with randomly placed idle cycles that carry random `bit_in`. It raises `resync` only between bursts. Streams are built from encoder-style bench functions, so every zero run stays within the limit, except in the one directed overflow case.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    typedef enum logic [1:0] {
        ST_HEADER,
        ST_LOW,
        ST_ZEROS,
        ST_HALT
    } rbd_state_e;

    // Header value to split factor; values above the widest split saturate.
    function automatic int unsigned id_to_k(input int unsigned id, input int unsigned kmax);
        return (id > kmax) ? kmax : id;
    endfunction

endpackage

// File: rtl/rbd_shreg.sv
module rbd_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    generate
        if (W == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= '0;
                else if (clr)      q <= '0;
                else if (shift_en) q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= '0;
                else if (clr)      q <= '0;
                else if (shift_en) q <= {q[W-2:0], din};
            end
        end
    endgenerate
endmodule

// File: rtl/rbd_upcnt.sv
module rbd_upcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + 1'b1;
    end
endmodule

// File: rtl/rbd_block_decoder.sv
module rbd_block_decoder
    import rbd_pkg::*;
#(
    parameter int SAMPLE_W  = 8,
    parameter int BLOCK_LEN = 8,
    parameter int HDR_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_vld,
    input  logic                bit_in,
    input  logic                resync,
    output logic                samp_vld,
    output logic [SAMPLE_W-1:0] samp_data,
    output logic                blk_done,
    output logic                err_flag
);
    localparam int K_W   = $clog2(SAMPLE_W);
    localparam int IDX_W = $clog2(BLOCK_LEN);
    localparam int POS_W = K_W;
    localparam logic [POS_W-1:0] HDR_LAST = POS_W'(HDR_W - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLOCK_LEN - 1);

    rbd_state_e state_q, state_d;

    logic [HDR_W-2:0]    hdr_q;
    logic [HDR_W-1:0]    hdr_full;
    logic [SAMPLE_W-1:0] low_q, cnt_q, cnt_max;
    logic [K_W-1:0]      k_q, k_new;
    logic [POS_W-1:0]    pos_q;
    logic [IDX_W-1:0]    idx_q;

    logic hdr_shift, low_shift, low_clr, cnt_clr, cnt_inc;
    logic pos_clr, pos_inc, idx_clr, idx_inc, k_load;
    logic emit, last, overflow;

    assign hdr_full = {hdr_q, bit_in};
    assign k_new    = K_W'(id_to_k(32'(hdr_full), SAMPLE_W - 1));
    assign cnt_max  = {SAMPLE_W{1'b1}} >> k_q;

    rbd_shreg #(.W(HDR_W-1)) u_hdr (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .shift_en(hdr_shift), .din(bit_in), .q(hdr_q));
    rbd_shreg #(.W(SAMPLE_W)) u_low (
        .clk(clk), .rst_n(rst_n), .clr(low_clr), .shift_en(low_shift), .din(bit_in), .q(low_q));
    rbd_upcnt #(.W(SAMPLE_W)) u_run (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .q(cnt_q));
    rbd_upcnt #(.W(POS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .clr(pos_clr), .inc(pos_inc), .q(pos_q));
    rbd_upcnt #(.W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc), .q(idx_q));

    // State register and split factor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HEADER;
            k_q     <= '0;
        end else begin
            state_q <= state_d;
            if (k_load) k_q <= k_new;
        end
    end

    // Next state and datapath strobes
    always_comb begin
        state_d   = state_q;
        hdr_shift = 1'b0;
        low_shift = 1'b0;
        low_clr   = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        pos_clr   = 1'b0;
        pos_inc   = 1'b0;
        idx_clr   = 1'b0;
        idx_inc   = 1'b0;
        k_load    = 1'b0;
        emit      = 1'b0;
        last      = 1'b0;
        overflow  = 1'b0;
        if (resync) begin
            state_d = ST_HEADER;
            pos_clr = 1'b1;
            idx_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_HEADER: if (bit_vld) begin
                    hdr_shift = 1'b1;
                    if (pos_q == HDR_LAST) begin
                        k_load  = 1'b1;
                        pos_clr = 1'b1;
                        low_clr = 1'b1;
                        cnt_clr = 1'b1;
                        state_d = (k_new == '0) ? ST_ZEROS : ST_LOW;
                    end else begin
                        pos_inc = 1'b1;
                    end
                end
                ST_LOW: if (bit_vld) begin
                    low_shift = 1'b1;
                    if (pos_q == k_q - 1'b1) begin
                        pos_clr = 1'b1;
                        state_d = ST_ZEROS;
                    end else begin
                        pos_inc = 1'b1;
                    end
                end
                ST_ZEROS: if (bit_vld) begin
                    if (!bit_in) begin
                        if (cnt_q == cnt_max) begin
                            overflow = 1'b1;
                            state_d  = ST_HALT;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end else begin
                        emit    = 1'b1;
                        low_clr = 1'b1;
                        cnt_clr = 1'b1;
                        if (idx_q == IDX_LAST) begin
                            last    = 1'b1;
                            idx_clr = 1'b1;
                            state_d = ST_HEADER;
                        end else begin
                            idx_inc = 1'b1;
                            state_d = (k_q == '0) ? ST_ZEROS : ST_LOW;
                        end
                    end
                end
                ST_HALT: state_d = ST_HALT;
                default: state_d = ST_HEADER;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_vld  <= 1'b0;
            samp_data <= '0;
            blk_done  <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            samp_vld <= emit;
            blk_done <= last;
            if (emit)          samp_data <= (cnt_q << k_q) | low_q;
            if (resync)        err_flag  <= 1'b0;
            else if (overflow) err_flag  <= 1'b1;
        end
    end
endmodule

// File: rtl/rbd_block_decoder_chk.sv
module rbd_block_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic bit_in,
    input logic resync,
    input logic samp_vld,
    input logic blk_done,
    input logic err_flag
);
    a_r4_vld_after_closing_one: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld |-> $past(bit_vld && bit_in && !resync));

    a_r5_done_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> samp_vld);

    a_r6_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !samp_vld);

    a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !resync) |=> err_flag);

    a_r7_silent_in_error: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !samp_vld);

    a_r8_resync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !err_flag);
endmodule

bind rbd_block_decoder rbd_block_decoder_chk chk_i (.*);

// File: tb/rbd_block_decoder_tb_top.sv
module rbd_block_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       resync = 1'b0;
    logic       samp_vld;
    logic [7:0] samp_data;
    logic       blk_done;
    logic       err_flag;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    bit         bitq[$];
    logic [7:0] exp_data[$];
    bit         exp_done[$];
    string      exp_tag[$];
    logic [7:0] blk[8];

    logic [7:0] m_d;
    bit         m_dn;
    string      m_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbd_block_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .resync(resync),
        .samp_vld(samp_vld), .samp_data(samp_data), .blk_done(blk_done), .err_flag(err_flag));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Encoder model: header, then per sample k raw bits, zero run, closing one.
    task automatic put_block(input int id, input bit want, input string tag);
        int k = id;
        for (int b = 2; b >= 0; b--) bitq.push_back(id[b]);
        for (int j = 0; j < 8; j++) begin
            logic [7:0] s = blk[j];
            int run = int'(s >> k);
            for (int b = k - 1; b >= 0; b--) bitq.push_back(s[b]);
            for (int z = 0; z < run; z++) bitq.push_back(1'b0);
            bitq.push_back(1'b1);
            if (want) begin
                exp_data.push_back(s);
                exp_done.push_back(j == 7);
                exp_tag.push_back(tag);
            end
        end
    endtask

    task automatic drive(input int gap_pct);
        while (bitq.size() > 0) begin
            if (int'($urandom % 100) < gap_pct) begin
                @(negedge clk);
                bit_vld = 1'b0;
                bit_in  = 1'($urandom);
            end
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in  = bitq.pop_front();
        end
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b0;
    endtask

    task automatic pulse_resync();
        @(negedge clk);
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
    endtask

    // Output monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (samp_vld) begin
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R7 sample while none expected", int'(samp_data), -1);
                end else begin
                    m_d  = exp_data.pop_front();
                    m_dn = exp_done.pop_front();
                    m_t  = exp_tag.pop_front();
                    chk(samp_data == m_d, m_t, int'(samp_data), int'(m_d));
                    chk(blk_done == m_dn, "R5 block-done on eighth sample", int'(blk_done), int'(m_dn));
                end
            end else if (blk_done) begin
                chk(1'b0, "R5 block-done without sample", 1, 0);
            end
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk(samp_vld == 1'b0, "R1 reset samp_vld", int'(samp_vld), 0);
        chk(blk_done == 1'b0, "R1 reset blk_done", int'(blk_done), 0);
        chk(err_flag == 1'b0, "R1 reset err_flag", int'(err_flag), 0);
        chk(samp_data == 8'd0, "R1 reset samp_data", int'(samp_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Header sweep over every split
        for (int id = 0; id < 8; id++) begin
            for (int j = 0; j < 8; j++) blk[j] = 8'(j * 53 + id * 29 + 7);
            put_block(id, 1'b1, "R2/R3/R4 header sweep");
            drive(0);
        end

        // Longest legal runs
        for (int j = 0; j < 8; j++) blk[j] = (j % 2 == 0) ? 8'hFF : 8'(j);
        put_block(0, 1'b1, "R4 k0 longest run");
        drive(10);
        for (int j = 0; j < 8; j++) blk[j] = (j % 2 == 0) ? 8'hFF : 8'h7F;
        put_block(7, 1'b1, "R4 k7 longest run");
        drive(10);

        // Back-to-back blocks, then heavy idle gaps
        for (int j = 0; j < 8; j++) blk[j] = 8'(j * 3);
        put_block(2, 1'b1, "R5 back-to-back first");
        for (int j = 0; j < 8; j++) blk[j] = 8'(255 - j * 17);
        put_block(5, 1'b1, "R5 back-to-back second");
        drive(0);
        for (int j = 0; j < 8; j++) blk[j] = 8'($urandom);
        put_block(3, 1'b1, "R6 idle cycles ignored");
        drive(60);

        // Random blocks
        for (int n = 0; n < 40; n++) begin
            int id = int'($urandom % 8);
            for (int j = 0; j < 8; j++) blk[j] = 8'($urandom);
            put_block(id, 1'b1, "R3/R4 random block");
            drive(25);
        end

        // Overflow with k = 7: the second zero exceeds the limit of one
        bitq = '{1, 1, 1, 1, 0, 1, 0, 1, 0, 1, 0, 0, 1, 0, 1, 1};
        drive(0);
        repeat (3) @(negedge clk);
        chk(err_flag == 1'b1, "R7 overflow sets error", int'(err_flag), 1);
        for (int j = 0; j < 8; j++) blk[j] = 8'(j);
        put_block(1, 1'b0, "unused");
        drive(0);
        repeat (3) @(negedge clk);
        chk(err_flag == 1'b1, "R7 error stays set", int'(err_flag), 1);
        chk(exp_data.size() == 0, "R7 no samples in error", exp_data.size(), 0);

        pulse_resync();
        chk(err_flag == 1'b0, "R8 resync clears error", int'(err_flag), 0);
        for (int j = 0; j < 8; j++) blk[j] = 8'(j * 31 + 1);
        put_block(4, 1'b1, "R8 decode after resync");
        drive(0);

        // Resync inside a block
        bitq = '{0, 1, 0, 1, 1, 0, 0, 0};
        drive(0);
        pulse_resync();
        for (int j = 0; j < 8; j++) blk[j] = 8'(200 - j * 9);
        put_block(6, 1'b1, "R8 resync mid-block");
        drive(20);

        repeat (5) @(negedge clk);
        chk(exp_data.size() == 0, "R4 all expected samples seen", exp_data.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        finished = 1'b1;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule